// File: doc/BRIEF.md
# Output-Stationary Convolution Processing Element

This block is one processing element of a one-dimensional convolution array in which every element owns one output pixel. The element has no sequencer of its own. A central controller drives it cycle by cycle. The controller loads the input samples that the pixel's window needs into a small local FIFO. It then streams one weight per cycle, together with an output-channel index and two flags that mark the first and last terms of the reduction. In each such cycle the element multiplies the weight by the sample at the head of its FIFO and accumulates the product into that channel's entry of a partial-sum store. The controller tells the element when to retire the head sample.

On the final term of a channel, the result goes into a separate output store instead of the partial-sum store. A later pixel can then accumulate while the finished results are read out. A read request names a channel and gets the stored word one cycle later. Weights are never stored in the element. Each accepted weight leaves on the neighbour-facing weight port one cycle after it arrives, so a row of elements forms a pipelined broadcast chain. An activity enable lets elements outside the current tile take part in that chain without touching any of their stores.

The sample input uses valid/ready. A sample is taken on a clock edge where both are high. Ready is low whenever the element is inactive or its FIFO is full, and the sender must hold the sample until it is taken. The weight chain and the read port carry no back-pressure. Their valid and request pins are plain per-cycle qualifiers, because the controller schedules both so that they can never be refused.

Top module: `conv_pe`

## Requirements
- R1: One cycle after every edge with `w_valid` high, `w_valid_o` is high and `w_data_o` equals that edge's `w_data`. One cycle after an edge with `w_valid` low, `w_valid_o` is low. This holds whatever the value of `act_en`.
- R2: On an edge with `act_en` and `w_valid` high and `first_term` low, the partial-sum entry for channel `och` becomes its old value plus `w_data` times the FIFO head sample. The arithmetic is 32-bit two's complement and wraps on overflow.
- R3: On such an edge with `first_term` high, the stored value is the product alone and the earlier contents of that channel are discarded.
- R4: On such an edge with `last_term` high, the result is written to the output store at channel `och`, and the partial-sum entry keeps its old value.
- R5: The FIFO holds 32 samples and returns them in arrival order. `in_ready` is high exactly when `act_en` is high and fewer than 32 samples are held. A full FIFO refuses a new sample even in a cycle where it also retires one.
- R6: `adv_in` high on an active edge removes the head sample if the FIFO is not empty. A multiply in that same cycle still uses the sample being removed.
- R7: While `act_en` is low, no store changes: the FIFO, the partial sums and the output store stay as they are, and `in_ready` is low.
- R8: One cycle after an edge with `rd_req` high, `rd_valid` is high and `rd_data` holds the output-store word for `rd_ch` as it stood before that edge. `rd_valid` is low otherwise.
- R9: During and right after reset, `w_valid_o` and `rd_valid` are low and the FIFO is empty.
- R10: The channel indices `och` and `rd_ch` reach every value from 0 to 511, and the lowest and highest channels are independent storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_en | input | 1 | Element belongs to the current tile; gates every store write |
| in_valid | input | 1 | Sample offered on `in_data` |
| in_ready | output | 1 | FIFO can take a sample this cycle |
| in_data | input | 32 | Input feature-map sample |
| adv_in | input | 1 | Retire the FIFO head sample |
| w_valid | input | 1 | Weight present on `w_data` |
| w_data | input | 32 | Broadcast weight, signed |
| first_term | input | 1 | First term of the reduction: overwrite instead of add |
| last_term | input | 1 | Last term: write the result to the output store |
| och | input | 9 | Output channel addressed by this weight |
| w_valid_o | output | 1 | Forwarded weight valid toward the next element |
| w_data_o | output | 32 | Forwarded weight |
| rd_req | input | 1 | Read request for the output store |
| rd_ch | input | 9 | Channel to read |
| rd_valid | output | 1 | Response to the request of the previous cycle |
| rd_data | output | 32 | Output-store word |

## Verification
The bound checker watches the cycle-level handshakes on every clock. It checks that the weight chain copies valid and data with exactly one cycle of delay, that each read request gets its response on the next cycle, that ready drops whenever the element is idle or its FIFO is full, and that the FIFO occupancy stays frozen while idle and falls by one when a sample is retired without a push. The arithmetic content can only be shown by the bench scenarios, which compare the element against a behavioural model on every cycle. That content covers accumulation across several channels and kernel positions, overwrite on the first term, and routing of the last term into the output store. The scenarios also show that a refused sample never appears later, that idle cycles leave stored results untouched when they are read back, and that channels 0 and 511 do not alias.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Destination selected for the result of one multiply-accumulate
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_PSUM = 2'd1,
    DST_OBUF = 2'd2
  } pe_dst_e;
endpackage

// File: rtl/pe_in_fifo.sv
module pe_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = store[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pe_chan_mem.sv
module pe_chan_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pe_mac.sv
module pe_mac
  import pe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] weight,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] psum_old,
  input  logic         first,
  input  logic         last,
  output pe_dst_e      dst,
  output logic [W-1:0] result
);
  logic [W-1:0] prod;

  // Low W bits of the product are identical for signed and unsigned operands
  assign prod   = weight * sample;
  assign result = (first ? '0 : psum_old) + prod;

  always_comb begin
    if (!en)       dst = DST_NONE;
    else if (last) dst = DST_OBUF;
    else           dst = DST_PSUM;
  end
endmodule

// File: rtl/conv_pe.sv
module conv_pe
  import pe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IBUF_DEPTH = 32,
  parameter int NUM_CH     = 512,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(IBUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              adv_in,
  input  logic              w_valid,
  input  logic [DATA_W-1:0] w_data,
  input  logic              first_term,
  input  logic              last_term,
  input  logic [CH_W-1:0]   och,
  output logic              w_valid_o,
  output logic [DATA_W-1:0] w_data_o,
  input  logic              rd_req,
  input  logic [CH_W-1:0]   rd_ch,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fill_cnt;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] psum_rd, obuf_rd, mac_res;
  pe_dst_e           dst;

  assign in_ready = act_en && !fifo_full;

  pe_in_fifo #(.W(DATA_W), .DEPTH(IBUF_DEPTH)) u_ibuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid && in_ready),
    .push_data (in_data),
    .pop       (act_en && adv_in),
    .head      (head),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .count     (fill_cnt)
  );

  pe_mac #(.W(DATA_W)) u_mac (
    .en       (act_en && w_valid),
    .weight   (w_data),
    .sample   (head),
    .psum_old (psum_rd),
    .first    (first_term),
    .last     (last_term),
    .dst      (dst),
    .result   (mac_res)
  );

  pe_chan_mem #(.W(DATA_W), .DEPTH(NUM_CH)) u_psum (
    .clk   (clk),
    .we    (dst == DST_PSUM),
    .waddr (och),
    .wdata (mac_res),
    .raddr (och),
    .rdata (psum_rd)
  );

  pe_chan_mem #(.W(DATA_W), .DEPTH(NUM_CH)) u_obuf (
    .clk   (clk),
    .we    (dst == DST_OBUF),
    .waddr (och),
    .wdata (mac_res),
    .raddr (rd_ch),
    .rdata (obuf_rd)
  );

  // Weight broadcast chain: one register stage toward the neighbour
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_valid_o <= 1'b0;
      w_data_o  <= '0;
    end else begin
      w_valid_o <= w_valid;
      if (w_valid) w_data_o <= w_data;
    end
  end

  // Sender: registered response to a read request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= obuf_rd;
    end
  end
endmodule

// File: rtl/conv_pe_chk.sv
module conv_pe_chk #(
  parameter int DATA_W     = 32,
  parameter int IBUF_DEPTH = 32,
  localparam int CNT_W = $clog2(IBUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic              adv_in,
  input logic              w_valid,
  input logic [DATA_W-1:0] w_data,
  input logic              w_valid_o,
  input logic [DATA_W-1:0] w_data_o,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  fill_cnt
);
  // R1
  w_fwd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |=> w_valid_o);
  // R1
  w_fwd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_valid |=> !w_valid_o);
  // R1
  w_fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |=> (w_data_o == $past(w_data)));
  // R8
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> !in_ready);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> (fill_cnt == $past(fill_cnt)));
  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(IBUF_DEPTH));
  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CNT_W'(IBUF_DEPTH)) |-> !in_ready);
  // R6
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && adv_in && fill_cnt != '0 && !(in_valid && in_ready))
      |=> (fill_cnt == $past(fill_cnt) - CNT_W'(1)));
endmodule

bind conv_pe conv_pe_chk #(.DATA_W(DATA_W), .IBUF_DEPTH(IBUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_en    (act_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .adv_in    (adv_in),
  .w_valid   (w_valid),
  .w_data    (w_data),
  .w_valid_o (w_valid_o),
  .w_data_o  (w_data_o),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .fill_cnt  (fill_cnt)
);

// File: tb/sim_conv_pe.sv
module sim_conv_pe;
  localparam int DW = 32;
  localparam int ID = 32;
  localparam int NC = 512;
  localparam int CW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, act_en, in_valid, in_ready, adv_in;
  logic [DW-1:0] in_data, w_data, w_data_o, rd_data;
  logic          w_valid, first_term, last_term, w_valid_o;
  logic [CW-1:0] och, rd_ch;
  logic          rd_req, rd_valid;

  conv_pe u0 (
    .clk(clk), .rst_n(rst_n), .act_en(act_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .adv_in(adv_in), .w_valid(w_valid), .w_data(w_data),
    .first_term(first_term), .last_term(last_term), .och(och),
    .w_valid_o(w_valid_o), .w_data_o(w_data_o),
    .rd_req(rd_req), .rd_ch(rd_ch), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // Behavioural reference state
  logic [DW-1:0] q[$];
  logic [DW-1:0] m_psum [NC];
  logic [DW-1:0] m_obuf [NC];
  logic          exp_wv = 1'b0, exp_rv = 1'b0;
  logic [DW-1:0] exp_wd = '0, exp_rd = '0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [DW-1:0] xval(int i);
    return DW'(i) * 32'h0123_4567 ^ 32'h8000_0001;
  endfunction

  function automatic logic [DW-1:0] wval(int n);
    return DW'(n * 7919 - 40000);
  endfunction

  function automatic logic [CW-1:0] och_of(int co);
    case (co)
      0:       return CW'(0);
      1:       return CW'(5);
      2:       return CW'(200);
      default: return CW'(511);
    endcase
  endfunction

  always @(posedge clk) begin
    logic [DW-1:0] head, prod, acc;
    logic          can_push;
    cycles++;
    if (!rst_n) begin
      q.delete();
      exp_wv = 1'b0;
      exp_rv = 1'b0;
    end else begin
      exp_wv = w_valid;
      if (w_valid) exp_wd = w_data;
      exp_rv = rd_req;
      if (rd_req) exp_rd = m_obuf[rd_ch];
      head = (q.size() > 0) ? q[0] : '0;
      if (act_en && w_valid) begin
        prod = w_data * head;
        acc  = first_term ? prod : m_psum[och] + prod;
        if (last_term) m_obuf[och] = acc;
        else           m_psum[och] = acc;
      end
      can_push = act_en && (q.size() < ID);
      if (act_en && adv_in && q.size() > 0) void'(q.pop_front());
      if (can_push && in_valid) q.push_back(in_data);
    end
    #5;
    chk("R1 R9 w_valid_o", {31'd0, w_valid_o}, {31'd0, exp_wv});
    if (exp_wv) chk("R1 w_data_o", w_data_o, exp_wd);
    chk("R8 R9 rd_valid", {31'd0, rd_valid}, {31'd0, exp_rv});
    if (exp_rv) chk("R2 R3 R4 R6 R10 rd_data", rd_data, exp_rd);
    chk("R5 R7 in_ready", {31'd0, in_ready},
        {31'd0, (act_en && q.size() < ID)});
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic quiet();
    in_valid = 0; adv_in = 0; w_valid = 0; first_term = 0; last_term = 0;
    rd_req = 0;
  endtask

  initial begin
    int xi;
    int wn;
    rst_n = 0; act_en = 1; in_data = '0; w_data = '0; och = '0; rd_ch = '0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Two windows of 9 samples (R5)
    xi = 0;
    for (int i = 0; i < 18; i++) begin
      in_valid = 1; in_data = xval(xi); xi++;
      @(negedge clk);
    end
    quiet();

    // Two channels x 9 positions x 4 outputs, with overlapped fill (R2 R3 R4 R6 R10)
    wn = 1;
    for (int ci = 0; ci < 2; ci++) begin
      for (int p = 0; p < 9; p++) begin
        for (int co = 0; co < 4; co++) begin
          w_valid = 1; w_data = wval(wn); wn++;
          och = och_of(co);
          first_term = (ci == 0 && p == 0);
          last_term  = (ci == 1 && p == 8);
          adv_in = (co == 3);
          in_valid = (ci == 1 && p == 0);
          in_data = xval(xi);
          if (in_valid) xi++;
          @(negedge clk);
        end
      end
    end
    quiet();
    for (int k = 0; k < 8; k++) begin
      in_valid = 1; in_data = xval(xi); xi++;
      @(negedge clk);
    end
    quiet();

    // Drain all four channels, including 0 and 511 (R8 R10)
    for (int co = 0; co < 4; co++) begin
      rd_req = 1; rd_ch = och_of(co);
      @(negedge clk);
    end
    quiet();

    // Idle element: every stimulus must be ignored (R7)
    act_en = 0;
    for (int k = 0; k < 6; k++) begin
      in_valid = 1; in_data = xval(xi + 100); adv_in = 1;
      w_valid = 1; w_data = wval(wn + k); och = CW'(0);
      first_term = 1; last_term = 1;
      @(negedge clk);
    end
    quiet();
    act_en = 1;
    rd_req = 1; rd_ch = CW'(0);
    @(negedge clk);
    rd_req = 1; rd_ch = CW'(511);
    @(negedge clk);
    quiet();

    // Fill past full: extra samples refused (R5)
    for (int k = 0; k < 30; k++) begin
      in_valid = 1; in_data = xval(xi); xi++;
      @(negedge clk);
    end
    // Push with pop while full: only the pop happens (R5 R6)
    in_valid = 1; in_data = 32'hDEAD_BEEF; adv_in = 1;
    @(negedge clk);
    quiet();

    // Direct single-term results into the output store (R3 R4 R6)
    for (int k = 0; k < 4; k++) begin
      w_valid = 1; w_data = wval(wn); wn++;
      och = CW'(7 + k); first_term = 1; last_term = 1; adv_in = 1;
      @(negedge clk);
    end
    // Two-term reduction on channel 20, read raced with the final write (R2 R4 R8)
    w_valid = 1; w_data = 32'h7FFF_FFFF; och = CW'(20); first_term = 1; last_term = 0;
    adv_in = 0;
    @(negedge clk);
    w_valid = 1; w_data = 32'hFFFF_FFFD; och = CW'(20); first_term = 0; last_term = 1;
    adv_in = 1; rd_req = 1; rd_ch = CW'(20);
    @(negedge clk);
    quiet();
    for (int k = 0; k < 4; k++) begin
      rd_req = 1; rd_ch = CW'(7 + k);
      @(negedge clk);
    end
    rd_req = 1; rd_ch = CW'(20);
    @(negedge clk);
    quiet();

    // Weight chain keeps running regardless of gaps (R1)
    for (int k = 0; k < 6; k++) begin
      w_valid = k[0]; w_data = wval(900 + k); och = CW'(300); first_term = 1;
      @(negedge clk);
    end
    quiet();

    // Reset again: chain and FIFO return to empty (R9)
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule